// File: doc/BRIEF.md
# Dual-Bank Bidirectional LCD Segment Driver

This block converts a serial stream of display bits into eighty latched segment drive codes. It is made of two independent banks of forty channels each. Every bank has its own shift-direction input and a pair of bidirectional data pins, so that banks can be chained into one another. A bit moves into a bank on each falling edge of a shift clock. A separate latch clock copies every bank bit into the output latches on its falling edge. The latched value together with an alternation input then selects one of four drive levels for each channel.

All slow control inputs are brought into a fast system clock domain through two-flop synchronisers, and edges are found on the synchronised copies. Each bidirectional pin appears as an input, an output and an output enable. The direction inputs are static configuration and must only change while no shift is in progress.

Top module: `lcdseg_dual_driver`

## Requirements
- R1: After reset both banks and all latches hold 0, so every channel shows the non-select code for the present alternation value (code 11 with alternation 0).
- R2: With bank A direction 0, a shift puts the left-pin bit into channel 1, moves channel k to channel k+1, and the right pin output carries channel 40.
- R3: With bank A direction 1, a shift puts the right-pin bit into channel 40, moves channel k to channel k-1, and the left pin output carries channel 1.
- R4: Bank B follows the rules of R2 and R3 on channels 41 to 80 with its own direction input and pins.
- R5: Each falling edge of the shift clock moves every bank by exactly one position, visible on the third rising system clock edge after the fall is applied; no other cycle changes bank contents.
- R6: A falling edge of the latch clock copies all 80 bank bits into the latches, visible on the third rising system clock edge after the fall; at no other time do the latched values change.
- R7: Channel k drives bits [2k-1:2k-2] of the code output: alternation 1 with data 1 gives 00, alternation 1 with data 0 gives 10, alternation 0 with data 1 gives 01, alternation 0 with data 0 gives 11.
- R8: For each bank, only the pin acting as output for the current direction has its output enable set (right pin for direction 0, left pin for direction 1).
- R9: When latch and shift clock fall in the same cycle, the latches receive the bank contents from before that shift.
- R10: A change of the alternation input reaches the codes on the second rising system clock edge after it is applied.
- R11: With bank A's right output wired to bank B's left input and both at direction 0, 80 shifts load the 80 channels as one chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| latch_clk_i | input | 1 | Latch clock, acts on falling edge |
| shift_clk_i | input | 1 | Shift clock, acts on falling edge |
| alt_i | input | 1 | Alternation input for waveform polarity |
| a_dir_i | input | 1 | Bank A shift direction (static) |
| b_dir_i | input | 1 | Bank B shift direction (static) |
| a_lpin_i | input | 1 | Bank A left pin input |
| a_lpin_o | output | 1 | Bank A left pin output (channel 1) |
| a_lpin_oe | output | 1 | Bank A left pin output enable |
| a_rpin_i | input | 1 | Bank A right pin input |
| a_rpin_o | output | 1 | Bank A right pin output (channel 40) |
| a_rpin_oe | output | 1 | Bank A right pin output enable |
| b_lpin_i | input | 1 | Bank B left pin input |
| b_lpin_o | output | 1 | Bank B left pin output (channel 41) |
| b_lpin_oe | output | 1 | Bank B left pin output enable |
| b_rpin_i | input | 1 | Bank B right pin input |
| b_rpin_o | output | 1 | Bank B right pin output (channel 80) |
| b_rpin_oe | output | 1 | Bank B right pin output enable |
| seg_code_o | output | 160 | Two-bit drive code per channel |

## Verification
A shift or latch fall lands on the third rising clock edge after the bench applies it (two synchroniser stages plus the register), and an alternation change lands on the second, while output enables follow the direction inputs at once. The bench keeps countdowns that apply each event to its queue model on exactly that edge, and compares every code and pin one nanosecond after every rising edge, so both an early and a late update show up as a miscompare. Serial data is set up several cycles before each clock fall so that it is already settled through its synchroniser.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  typedef logic [1:0] drive_code_t;

  // drive level codes
  localparam drive_code_t LVL_SEL_HI  = 2'b00;
  localparam drive_code_t LVL_SEL_LO  = 2'b01;
  localparam drive_code_t LVL_NSEL_HI = 2'b10;
  localparam drive_code_t LVL_NSEL_LO = 2'b11;

  // choose a drive level from a latched bit and the alternation phase
  function automatic drive_code_t drive_code(input logic on, input logic alt);
    drive_code_t c;
    case ({alt, on})
      2'b11:   c = LVL_SEL_HI;
      2'b10:   c = LVL_NSEL_HI;
      2'b01:   c = LVL_SEL_LO;
      default: c = LVL_NSEL_LO;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lcdseg_sync.sv
module lcdseg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/lcdseg_bank.sv
module lcdseg_bank #(
  parameter int NCH = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_i,
  input  logic           dir_i,
  input  logic           lpin_i,
  input  logic           rpin_i,
  output logic           lpin_o,
  output logic           lpin_oe,
  output logic           rpin_o,
  output logic           rpin_oe,
  output logic [NCH-1:0] bits_o
);
  localparam int LAST = NCH - 1;

  logic [NCH-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else if (step_i) begin
      if (dir_i) bits <= {rpin_i, bits[LAST:1]};
      else       bits <= {bits[LAST-1:0], lpin_i};
    end
  end

  assign lpin_o  = bits[0];
  assign rpin_o  = bits[LAST];
  assign lpin_oe = dir_i;
  assign rpin_oe = ~dir_i;
  assign bits_o  = bits;

  // R2 (and R4 for the second bank): forward shift enters at channel 1
  a_r2_fwd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !dir_i) |=> (bits[0] == $past(lpin_i)) && (bits[LAST:1] == $past(bits[LAST-1:0])));

  // R3 (and R4 for the second bank): reverse shift enters at the last channel
  a_r3_rev_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && dir_i) |=> (bits[LAST] == $past(rpin_i)) && (bits[LAST-1:0] == $past(bits[LAST:1])));

  // R5: contents move only on a shift event
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(bits));
endmodule

// File: rtl/lcdseg_out.sv
module lcdseg_out
  import lcdseg_pkg::*;
#(
  parameter int NCH = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [NCH-1:0]   src_i,
  input  logic             alt_i,
  output logic [2*NCH-1:0] code_o
);
  logic [NCH-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (cap_i) held <= src_i;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    assign code_o[2*k +: 2] = drive_code(held[k], alt_i);
  end

  // R6: latches load all channels on a capture event
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> held == $past(src_i));

  // R6: latches hold between capture events
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(held));
endmodule

// File: rtl/lcdseg_dual_driver.sv
module lcdseg_dual_driver #(
  parameter int BANK_CH = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 latch_clk_i,
  input  logic                 shift_clk_i,
  input  logic                 alt_i,
  input  logic                 a_dir_i,
  input  logic                 b_dir_i,
  input  logic                 a_lpin_i,
  output logic                 a_lpin_o,
  output logic                 a_lpin_oe,
  input  logic                 a_rpin_i,
  output logic                 a_rpin_o,
  output logic                 a_rpin_oe,
  input  logic                 b_lpin_i,
  output logic                 b_lpin_o,
  output logic                 b_lpin_oe,
  input  logic                 b_rpin_i,
  output logic                 b_rpin_o,
  output logic                 b_rpin_oe,
  output logic [4*BANK_CH-1:0] seg_code_o
);
  localparam int TOTAL_CH = 2 * BANK_CH;
  localparam int NSYNC    = 7;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn_in;
  logic latch_s, shift_s, alt_s;
  logic a_l_s, a_r_s, b_l_s, b_r_s;
  logic latch_prev, shift_prev;
  logic latch_evt, shift_evt;
  logic [BANK_CH-1:0] a_bits, b_bits;

  assign raw_in = {latch_clk_i, shift_clk_i, alt_i, a_lpin_i, a_rpin_i, b_lpin_i, b_rpin_i};

  lcdseg_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {latch_s, shift_s, alt_s, a_l_s, a_r_s, b_l_s, b_r_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_prev <= 1'b0;
      shift_prev <= 1'b0;
    end else begin
      latch_prev <= latch_s;
      shift_prev <= shift_s;
    end
  end

  assign latch_evt = latch_prev & ~latch_s;
  assign shift_evt = shift_prev & ~shift_s;

  lcdseg_bank #(.NCH(BANK_CH)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .step_i(shift_evt), .dir_i(a_dir_i),
    .lpin_i(a_l_s), .rpin_i(a_r_s),
    .lpin_o(a_lpin_o), .lpin_oe(a_lpin_oe),
    .rpin_o(a_rpin_o), .rpin_oe(a_rpin_oe),
    .bits_o(a_bits)
  );

  lcdseg_bank #(.NCH(BANK_CH)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .step_i(shift_evt), .dir_i(b_dir_i),
    .lpin_i(b_l_s), .rpin_i(b_r_s),
    .lpin_o(b_lpin_o), .lpin_oe(b_lpin_oe),
    .rpin_o(b_rpin_o), .rpin_oe(b_rpin_oe),
    .bits_o(b_bits)
  );

  lcdseg_out #(.NCH(TOTAL_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .cap_i(latch_evt),
    .src_i({b_bits, a_bits}), .alt_i(alt_s), .code_o(seg_code_o)
  );

  // R5: two shift events can never be adjacent (one step per falling edge)
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> !shift_evt);

  // R9: a coincident latch sees the banks as they were before the shift
  a_r9_pre_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && shift_evt) |=> (u_out.held == $past({b_bits, a_bits})));
endmodule

// File: tb/lcdseg_dual_driver_test.sv
module lcdseg_dual_driver_test;
  localparam int NB = 40;
  localparam int NT = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lclk = 1'b1, sclk = 1'b1, alt = 1'b0;
  logic a_dir = 1'b0, b_dir = 1'b0;
  logic a_l = 1'b0, a_r = 1'b0, b_l_drv = 1'b0, b_r = 1'b0;
  logic casc = 1'b0;
  logic a_lo, a_loe, a_ro, a_roe, b_lo, b_loe, b_ro, b_roe;
  logic b_l;
  logic [2*NT-1:0] codes;

  assign b_l = casc ? a_ro : b_l_drv;

  always #2 clk = ~clk;

  lcdseg_dual_driver uut (
    .clk(clk), .rst_n(rst_n), .latch_clk_i(lclk), .shift_clk_i(sclk), .alt_i(alt),
    .a_dir_i(a_dir), .b_dir_i(b_dir),
    .a_lpin_i(a_l), .a_lpin_o(a_lo), .a_lpin_oe(a_loe),
    .a_rpin_i(a_r), .a_rpin_o(a_ro), .a_rpin_oe(a_roe),
    .b_lpin_i(b_l), .b_lpin_o(b_lo), .b_lpin_oe(b_loe),
    .b_rpin_i(b_r), .b_rpin_o(b_ro), .b_rpin_oe(b_roe),
    .seg_code_o(codes)
  );

  // behavioural model: index 0 of each queue is the bank's lowest channel
  bit qa[$];
  bit qb[$];
  bit lat[NT];
  bit m_alt = 1'b0, pend_alt;
  int sh_cnt = 0, la_cnt = 0, al_cnt = 0;
  bit pa_l, pa_r, pb_l, pb_r;
  int vectors = 0, fails = 0;
  bit done = 1'b0;
  string phase = "R1";

  function automatic logic [1:0] want(input bit d, input bit m);
    if (m) return d ? 2'b00 : 2'b10;
    else   return d ? 2'b01 : 2'b11;
  endfunction

  task automatic model_shift();
    bit old_a_far;
    bit inb;
    old_a_far = qa[NB-1];
    if (!a_dir) begin qa.push_front(pa_l); void'(qa.pop_back()); end
    else        begin qa.push_back(pa_r);  void'(qa.pop_front()); end
    inb = casc ? old_a_far : pb_l;
    if (!b_dir) begin qb.push_front(inb);  void'(qb.pop_back()); end
    else        begin qb.push_back(pb_r);  void'(qb.pop_front()); end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (al_cnt > 0) begin al_cnt--; if (al_cnt == 0) m_alt = pend_alt; end
      if (la_cnt > 0) begin
        la_cnt--;
        if (la_cnt == 0)
          for (int i = 0; i < NT; i++) lat[i] = (i < NB) ? qa[i] : qb[i-NB];
      end
      if (sh_cnt > 0) begin sh_cnt--; if (sh_cnt == 0) model_shift(); end
    end
  end

  task automatic miss(input string what, input int got, input int exp);
    fails++;
    if (fails < 25) $display("FAIL %s %s got %0d expected %0d at %0t", phase, what, got, exp, $time);
  endtask

  // per-cycle comparison, away from the active edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      bit bad;
      bad = 1'b0;
      vectors++;
      for (int i = 0; i < NT; i++) begin
        if (!bad && codes[2*i +: 2] !== want(lat[i], m_alt)) begin
          bad = 1'b1;
          miss($sformatf("code ch%0d", i+1), codes[2*i +: 2], want(lat[i], m_alt));
        end
      end
      // R8: output enables follow the direction inputs
      if (!bad && ({a_loe, a_roe, b_loe, b_roe} !== {a_dir, !a_dir, b_dir, !b_dir})) begin
        bad = 1'b1;
        miss("R8 oe", {a_loe, a_roe, b_loe, b_roe}, {a_dir, !a_dir, b_dir, !b_dir});
      end
      if (!bad && a_dir && a_lo !== qa[0])        begin bad = 1'b1; miss("bankA left out", a_lo, qa[0]); end
      if (!bad && !a_dir && a_ro !== qa[NB-1])    begin bad = 1'b1; miss("bankA right out", a_ro, qa[NB-1]); end
      if (!bad && b_dir && b_lo !== qb[0])        begin bad = 1'b1; miss("bankB left out", b_lo, qb[0]); end
      if (!bad && !b_dir && b_ro !== qb[NB-1])    begin bad = 1'b1; miss("bankB right out", b_ro, qb[NB-1]); end
    end
  end

  task automatic pulse(input bit do_sh, input bit do_la, input bit al, input bit ar, input bit bl, input bit br);
    a_l = al; a_r = ar; b_l_drv = bl; b_r = br;
    repeat (3) @(negedge clk);
    if (do_sh) begin sclk = 1'b0; pa_l = al; pa_r = ar; pb_l = bl; pb_r = br; sh_cnt = 3; end
    if (do_la) begin lclk = 1'b0; la_cnt = 3; end
    repeat (4) @(negedge clk);
    sclk = 1'b1; lclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_alt(input bit v);
    @(negedge clk);
    alt = v; pend_alt = v; al_cnt = 2;
    repeat (4) @(negedge clk);
  endtask

  function automatic bit pat(input int i, input int seed);
    return ((i * 5 + seed) % 3) == 0;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";                     // reset state: all channels code 11
    repeat (6) @(negedge clk);
    phase = "R10";                    // alternation latency on non-select codes
    set_alt(1'b1);
    set_alt(1'b0);

    phase = "R2/R4";                  // forward direction in both banks, outputs hold (R6)
    a_dir = 1'b0; b_dir = 1'b0;
    for (int i = 0; i < NB; i++) pulse(1'b1, 1'b0, pat(i, 0), 1'b0, pat(i, 1), 1'b0);
    phase = "R6";
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    phase = "R3/R4";                  // reverse direction in both banks
    @(negedge clk);
    a_dir = 1'b1; b_dir = 1'b1;
    for (int i = 0; i < NB; i++) pulse(1'b1, 1'b0, 1'b0, pat(i, 2), 1'b0, !pat(i, 0));
    phase = "R6";
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    phase = "R7";                     // all four codes as alternation toggles
    set_alt(1'b1);
    set_alt(1'b0);
    set_alt(1'b1);

    phase = "R11";                    // bank A chained into bank B
    @(negedge clk);
    a_dir = 1'b0; b_dir = 1'b0; casc = 1'b1;
    for (int i = 0; i < NT; i++) pulse(1'b1, 1'b0, pat(i, 1) ^ (i > 60), 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    phase = "R9";                     // coincident latch and shift
    pulse(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    phase = "R5";                     // single steps with the latch afterwards
    pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    set_alt(1'b0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule